// File: doc/BRIEF.md
# Accelerator event and interrupt collector

This block sits between three accelerator sub-units and the interrupt controller. The sub-units are a bulk cipher engine, a random number source and a public-key / key-generation unit, and each one raises a completion line that stays high while its condition holds. The block watches each line and latches an event flag when the line rises. It also combines the flags with a per-source enable vector into one level interrupt.

Software reads and clears the event flags over a simple register bus. It controls the enable vector through three views: a direct register, a write-1-to-set register and a write-1-to-clear register. A flag that software clears while its source line is still high is set again at once, so a pending condition cannot be lost. Each source keeps its stored line level in a two-state machine. The states are `LVL_LOW` and `LVL_HIGH`. The transition `RISE` (LVL_LOW to LVL_HIGH) latches the event, and the transition `FALL` (LVL_HIGH to LVL_LOW) only updates the stored level.

Register word addresses: 0x0 cipher event, 0x1 random event, 0x2 public-key event, 0x4 enable (direct), 0x5 enable set, 0x6 enable clear. Any other address reads 0 and ignores writes. A write takes effect at the clock edge where `wr_en_i` is high. Reads are combinational from `addr_i`.

Top module: `evt_irq_wrap`

## Requirements
- R1: Reset clears all three event flags, the enable vector, the interrupt output and the stored line levels. A source line that is already high when reset is released therefore produces an event on the first clock edge after release.
- R2: At a clock edge where a source line is high and its stored level is low, that source's event flag becomes 1. The event registers return the flag in bit 0, and the other bits read 0.
- R3: At a clock edge where a source line is low and its stored level is high, only the stored level changes and the event flag keeps its value.
- R4: A write to an event register stores bit 0 of the write data in the flag: 0 clears it and 1 sets it. This holds when the source line is low.
- R5: A write to an event register while that source's line is high leaves the flag at 1.
- R6: When a rising edge on a source line and a write of 0 to the same event register happen at the same edge, the flag ends set.
- R7: The interrupt output is high exactly when, at the previous clock edge, some source had both its event flag and its enable bit set. It is registered and lags the flag or enable change by one clock.
- R8: A write to the direct enable register replaces the enable vector with write data bits [2:0]. Bit 0 is the cipher engine, bit 1 the random source and bit 2 the public-key unit. Reading the direct, set or clear enable register returns the vector in bits [2:0].
- R9: A write to the enable-set register sets the enable bits that are 1 in the write data and leaves the other bits unchanged.
- R10: A write to the enable-clear register clears the enable bits that are 1 in the write data and leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl_i | input | 3 | Source level lines: bit 0 cipher, bit 1 random, bit 2 public-key |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` |
| irq_o | output | 1 | Combined level interrupt |

## Verification
A stored line level that disagrees with the real line shows up on the first edge after the next line change. It appears either as a missing flag after a rise or as a spurious flag, and a read of that event register reveals it in the following low clock phase. A wrong flag or enable bit is visible on a read straight away and reaches `irq_o` one clock later. The bench therefore checks every step both through reads and through the interrupt with that one-clock lag. The re-arm and same-edge cases are driven on purpose, because an ordering error there loses an event without any other symptom.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int NUM_SRC = 3;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;

    // Word addresses; source index i maps to EVT_BASE + i
    localparam logic [ADDR_W-1:0] EVT_BASE = 4'h0;
    localparam logic [ADDR_W-1:0] EN_DIR   = 4'h4;
    localparam logic [ADDR_W-1:0] EN_SET   = 4'h5;
    localparam logic [ADDR_W-1:0] EN_CLR   = 4'h6;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_lvl_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    lvl_state_e state_q, state_d;
    logic       rise;
    logic       flag_q, flag_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // Next state and edge output
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (src_lvl_i) begin
                    state_d = LVL_HIGH;   // RISE
                    rise    = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!src_lvl_i) state_d = LVL_LOW;   // FALL
            end
            default: state_d = LVL_LOW;
        endcase
    end

    // Event flag: a write stores bit 0, re-armed while the line stays high
    always_comb begin
        if (wr_i) flag_d = wbit_i | src_lvl_i;
        else      flag_d = flag_q | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lvl_i && state_q == LVL_LOW && !wr_i) |=> flag_q);
    a_r3_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_lvl_i && state_q == LVL_HIGH && !wr_i) |=> $stable(flag_q));
    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && src_lvl_i) |=> flag_q);
    a_r6_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wbit_i && src_lvl_i && state_q == LVL_LOW) |=> (flag_q && state_q == LVL_HIGH));
endmodule

// File: rtl/irq_mask.sv
module irq_mask
    import evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_dir_i,
    input  logic               wr_set_i,
    input  logic               wr_clr_i,
    input  logic [NUM_SRC-1:0] wbits_i,
    input  logic [NUM_SRC-1:0] flags_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] en_q, en_d;
    logic               irq_q;

    always_comb begin
        en_d = en_q;
        if (wr_dir_i)      en_d = wbits_i;
        else if (wr_set_i) en_d = en_q | wbits_i;
        else if (wr_clr_i) en_d = en_q & ~wbits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            irq_q <= |(flags_i & en_q);
        end
    end

    assign en_o  = en_q;
    assign irq_o = irq_q;

    a_r9_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set_i && !wr_dir_i) |=> (en_q == ($past(en_q) | $past(wbits_i))));
    a_r10_clr_andn: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr_i && !wr_dir_i && !wr_set_i) |=> ((en_q & $past(wbits_i)) == '0));
    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & en_q) == '0) |=> !irq_q);
    a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & en_q) != '0) |=> irq_q);
endmodule

// File: rtl/evt_irq_wrap.sv
module evt_irq_wrap
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        src_lvl_i,
    input  logic              wr_en_i,
    input  logic [3:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] evt_wr;
    logic [NUM_SRC-1:0] en;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign evt_wr[g] = wr_en_i && (addr_i == EVT_BASE + ADDR_W'(g));
        evt_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_lvl_i (src_lvl_i[g]),
            .wr_i      (evt_wr[g]),
            .wbit_i    (wdata_i[0]),
            .flag_o    (flags[g])
        );
    end

    irq_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dir_i (wr_en_i && addr_i == EN_DIR),
        .wr_set_i (wr_en_i && addr_i == EN_SET),
        .wr_clr_i (wr_en_i && addr_i == EN_CLR),
        .wbits_i  (wdata_i[NUM_SRC-1:0]),
        .flags_i  (flags),
        .en_o     (en),
        .irq_o    (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr_i == EVT_BASE + ADDR_W'(i)) rdata_o[0] = flags[i];
        end
        if (addr_i == EN_DIR || addr_i == EN_SET || addr_i == EN_CLR)
            rdata_o[NUM_SRC-1:0] = en;
    end

    a_r8_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == EN_DIR) |=> (en == $past(wdata_i[NUM_SRC-1:0])));
endmodule

// File: tb/test_evt_irq_wrap.sv
`timescale 1ns/10ps
module test_evt_irq_wrap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    evt_irq_wrap i_evt_irq_wrap (
        .clk(clk), .rst_n(rst_n), .src_lvl_i(src), .wr_en_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [2:0] src;
        logic       wr;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic [2:0] flags;
        logic [2:0] en;
    } step_t;

    // src, wr, addr, wdata, expected flags, expected enable
    localparam step_t VEC [15] = '{
        '{3'b001, 1'b0, 4'h0, 8'h00, 3'b001, 3'b000},  // R2 rise
        '{3'b000, 1'b0, 4'h0, 8'h00, 3'b001, 3'b000},  // R3 fall keeps
        '{3'b000, 1'b1, 4'h0, 8'h00, 3'b000, 3'b000},  // R4 clear
        '{3'b010, 1'b1, 4'h4, 8'h05, 3'b010, 3'b101},  // R8 direct
        '{3'b010, 1'b1, 4'h1, 8'h00, 3'b010, 3'b101},  // R5 re-arm
        '{3'b010, 1'b1, 4'h5, 8'h02, 3'b010, 3'b111},  // R9 set
        '{3'b010, 1'b0, 4'h0, 8'h00, 3'b010, 3'b111},  // R7 irq up
        '{3'b000, 1'b1, 4'h6, 8'h02, 3'b010, 3'b101},  // R10 clear
        '{3'b000, 1'b0, 4'h0, 8'h00, 3'b010, 3'b101},  // R7 irq down
        '{3'b100, 1'b1, 4'h2, 8'h00, 3'b110, 3'b101},  // R6 same edge
        '{3'b100, 1'b1, 4'h1, 8'h00, 3'b100, 3'b101},  // R4 clear
        '{3'b100, 1'b1, 4'h4, 8'h00, 3'b100, 3'b000},  // R8 direct zero
        '{3'b100, 1'b0, 4'h0, 8'h00, 3'b100, 3'b000},  // R7 masked
        '{3'b000, 1'b1, 4'h2, 8'h00, 3'b000, 3'b000},  // R4 clear
        '{3'b000, 1'b1, 4'h0, 8'h01, 3'b001, 3'b000}   // R4 write 1 sets
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a falling edge with the bus idle
    task automatic read_all(output logic [2:0] f, output logic [2:0] e, output logic [31:0] raw1);
        addr = 4'h0; #0.2; f[0] = rdata[0];
        addr = 4'h1; #0.2; f[1] = rdata[0]; raw1 = rdata;
        addr = 4'h2; #0.2; f[2] = rdata[0];
        addr = 4'h5; #0.2; e = rdata[2:0];
    endtask

    task automatic run_step(input step_t s, input logic exp_irq);
        logic [2:0] f, e;
        logic [31:0] r1;
        src = s.src;
        if (s.wr) begin
            wr = 1'b1; addr = s.addr; wdata = {24'b0, s.wdata};
        end
        @(posedge clk); @(negedge clk);
        wr = 1'b0; wdata = '0;
        #0.1;
        chk("R7 irq", {31'b0, irq}, {31'b0, exp_irq});
        read_all(f, e, r1);
        chk("R2/R3/R4/R5/R6 flags", {29'b0, f}, {29'b0, s.flags});
        chk("R8/R9/R10 enable", {29'b0, e}, {29'b0, s.en});
        chk("R2 upper bits zero", {r1[31:1], 1'b0}, 32'h0);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] f, e;
        logic [31:0] r1;
        logic prev_irq;
        // R1: reset state
        repeat (3) @(negedge clk);
        #0.1;
        chk("R1 irq in reset", {31'b0, irq}, 32'h0);
        read_all(f, e, r1);
        chk("R1 flags in reset", {29'b0, f}, 32'h0);
        chk("R1 enable in reset", {29'b0, e}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        prev_irq = 1'b0;
        for (int k = 0; k < 15; k++) begin
            run_step(VEC[k], prev_irq);
            prev_irq = |(VEC[k].flags & VEC[k].en);
        end

        // R10: clear view reads the vector too; R8 direct view as well
        run_step('{3'b000, 1'b1, 4'h4, 8'h03, 3'b001, 3'b011}, 1'b0);
        addr = 4'h6; #0.2;
        chk("R10 clear view readback", rdata, 32'h3);
        addr = 4'h4; #0.2;
        chk("R8 direct view readback", rdata, 32'h3);
        addr = 4'h9; #0.2;
        chk("R8 unmapped reads zero", rdata, 32'h0);

        // R1: reset mid-run clears all, line high through reset
        @(negedge clk);
        src = 3'b010;
        rst_n = 1'b0;
        #0.1;
        chk("R1 irq cleared by reset", {31'b0, irq}, 32'h0);
        read_all(f, e, r1);
        chk("R1 flags cleared", {29'b0, f}, 32'h0);
        chk("R1 enable cleared", {29'b0, e}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk); #0.1;
        read_all(f, e, r1);
        chk("R1 level reset gives event", {29'b0, f}, 32'h2);

        // R5: clearing a held line keeps the flag; R7 via enable-set
        run_step('{3'b010, 1'b1, 4'h5, 8'h02, 3'b010, 3'b010}, 1'b0);
        run_step('{3'b010, 1'b1, 4'h1, 8'h00, 3'b010, 3'b010}, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule